// File: doc/BRIEF.md
# Dual-Width ROM Read Port

This block is a clock-synchronous model of the read side of a read-only memory whose data bus can be set to either 16 or 8 bits. Two active-low controls gate it. A chip select (`ce_n`) decides between standby and active operation. An output gate (`oe_n`) decides whether the data pins are driven. A width-select input picks word or byte organisation. In byte organisation, the pin that normally carries data bit 15 becomes the lowest address bit (`ext_lsb`), and it chooses which half of the addressed word appears on the low eight data pins.

Tri-state behaviour is modelled by a per-bit drive-enable bus beside the data bus. Data that is not yet valid, or not driven, reads as zero. Access time is modelled in clock cycles. A long latency counts from address stability or chip select, and a shorter one counts from the output gate. A digital identification flag stands in for the high-voltage condition. When it is set, the port returns a fixed manufacturer or device code instead of array contents. The storage array is filled through a simple load port before reads begin.

Top module: `dwrom_port`

## Requirements
- R1: While `rst` is high and on the first sampled cycle after it, `data_valid` is 0 and both access counters are cleared.
- R2: With `wide_sel`=1, `ce_n`=0 and `oe_n`=0, all 16 bits of `dq_oe` are 1 and, once valid, `dq_out` equals the stored word at `addr`.
- R3: With `wide_sel`=0 and the port enabled, only bits 7..0 are driven. `ext_lsb`=0 returns bits 7..0 of the stored word and `ext_lsb`=1 returns bits 15..8, both on `dq_out[7:0]`. Bits 15..8 of `dq_oe` are 0.
- R4: Data pins are driven only when `ce_n`=0 and `oe_n`=0. With `ce_n`=0 and `oe_n`=1, `dq_oe` is all zero and `data_valid` is 0.
- R5: With `ce_n`=1, `standby` is 1 and `dq_oe` is all zero whatever `oe_n` is.
- R6: With `id_flag`=1, the returned value ignores the array. `addr[0]`=0 gives 0x20 and `addr[0]`=1 gives 0xB8 on bits 7..0, with bits 15..8 zero.
- R7: The address counter restarts on any clock edge where `ce_n` is 1 or where `addr`, `wide_sel`, `id_flag` or (in byte mode) `ext_lsb` differ from the previous edge. Otherwise it counts up to ADDR_LAT. Data is valid only when it has reached ADDR_LAT.
- R8: The output-gate counter restarts on any edge where `ce_n` or `oe_n` is 1, and otherwise counts up to OE_LAT. Data is valid only when it has reached OE_LAT.
- R9: A change of `wide_sel` while enabled restarts the address counter (R7). The upper eight drive enables drop in the same cycle that `wide_sel` falls.
- R10: Whenever `data_valid` is 0, `dq_out` is all zero. Bits whose `dq_oe` is 0 also read zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| ld_en | input | 1 | Array load strobe |
| ld_addr | input | ADDR_W | Array load word address |
| ld_data | input | 16 | Array load word |
| ce_n | input | 1 | Chip select, active low |
| oe_n | input | 1 | Output gate, active low |
| wide_sel | input | 1 | 1 = 16-bit organisation, 0 = 8-bit |
| id_flag | input | 1 | Identification-code mode request |
| addr | input | ADDR_W | Word address |
| ext_lsb | input | 1 | Shared pin read as byte select in 8-bit mode |
| dq_out | output | 16 | Data bus value |
| dq_oe | output | 16 | Per-bit drive enable (0 = high impedance) |
| data_valid | output | 1 | Access time has elapsed for the driven data |
| standby | output | 1 | Port is in standby |

## Verification
The embedded properties watch several things on every cycle. They confirm that standby releases every pin, that byte mode never drives the upper lane, and that `data_valid` never rises without both enables. They also check that identification reads keep the upper byte clear, that invalid data reads as zero, and that each counter resets on the edges that must restart it. The returned values themselves can only be shown by the bench scenarios, which compare the port against a behavioural model on every clock. These values are the word selected from the array, the byte picked by the shared pin, the two identification codes, and the exact cycle on which valid data appears after an address change, a chip-select fall, an output-gate fall or a width switch.

// File: rtl/dwrom_pkg.sv
package dwrom_pkg;

    localparam int DQ_W   = 16;
    localparam int BYTE_W = 8;

    localparam logic [BYTE_W-1:0] MFR_CODE = 8'h20;
    localparam logic [BYTE_W-1:0] DEV_CODE = 8'hB8;

    typedef enum logic [1:0] {
        LANE_OFF  = 2'd0,
        LANE_WORD = 2'd1,
        LANE_BYTE = 2'd2
    } lane_e;

    typedef struct packed {
        logic [DQ_W-1:0] data;
        logic [DQ_W-1:0] drive;
    } lane_s;

    function automatic logic [DQ_W-1:0] half_of(input logic [DQ_W-1:0] w, input logic hi);
        return hi ? {{BYTE_W{1'b0}}, w[DQ_W-1:BYTE_W]} : {{BYTE_W{1'b0}}, w[BYTE_W-1:0]};
    endfunction

    function automatic logic [DQ_W-1:0] ident(input logic sel);
        return {{BYTE_W{1'b0}}, (sel ? DEV_CODE : MFR_CODE)};
    endfunction

endpackage

// File: rtl/dwrom_store.sv
module dwrom_store #(
    parameter int ADDR_W = 8,
    parameter int DATA_W = 16
) (
    input  logic              clk,
    input  logic              we,
    input  logic [ADDR_W-1:0] waddr,
    input  logic [DATA_W-1:0] wdata,
    input  logic [ADDR_W-1:0] raddr,
    output logic [DATA_W-1:0] rdata
);
    localparam int DEPTH = 1 << ADDR_W;

    logic [DATA_W-1:0] cells [DEPTH];

    always_ff @(posedge clk) begin
        if (we) begin
            cells[waddr] <= wdata;
        end
    end

    assign rdata = cells[raddr];

endmodule

// File: rtl/dwrom_access_timer.sv
module dwrom_access_timer #(
    parameter int ADDR_W   = 8,
    parameter int ADDR_LAT = 4,
    parameter int OE_LAT   = 2
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              ce_n,
    input  logic              oe_n,
    input  logic              wide_sel,
    input  logic              id_flag,
    input  logic [ADDR_W-1:0] addr,
    input  logic              ext_lsb,
    output logic              timing_ok
);
    localparam int AC_W = $clog2(ADDR_LAT + 1);
    localparam int OC_W = $clog2(OE_LAT + 1);
    localparam logic [AC_W-1:0] A_MAX = AC_W'(ADDR_LAT);
    localparam logic [OC_W-1:0] O_MAX = OC_W'(OE_LAT);

    logic [AC_W-1:0]   acnt;
    logic [OC_W-1:0]   ocnt;
    logic [ADDR_W-1:0] addr_q;
    logic              wide_q, id_q, lsb_q;
    logic              moved, a_restart, o_restart, a_done, o_done;

    assign moved     = (addr != addr_q) || (wide_sel != wide_q) || (id_flag != id_q)
                     || (!wide_sel && (ext_lsb != lsb_q));
    assign a_restart = ce_n || moved;
    assign o_restart = ce_n || oe_n;
    assign a_done    = (acnt == A_MAX);
    assign o_done    = (ocnt == O_MAX);
    assign timing_ok = a_done && o_done && !moved;

    always_ff @(posedge clk) begin
        if (rst) begin
            acnt   <= '0;
            ocnt   <= '0;
            addr_q <= '0;
            wide_q <= 1'b0;
            id_q   <= 1'b0;
            lsb_q  <= 1'b0;
        end else begin
            addr_q <= addr;
            wide_q <= wide_sel;
            id_q   <= id_flag;
            lsb_q  <= ext_lsb;
            if (a_restart)    acnt <= '0;
            else if (!a_done) acnt <= acnt + 1'b1;
            if (o_restart)    ocnt <= '0;
            else if (!o_done) ocnt <= ocnt + 1'b1;
        end
    end

    AST_ADDR_RESTART: assert property (@(posedge clk) disable iff (rst)
        a_restart |=> !a_done); // R7
    AST_OE_RESTART: assert property (@(posedge clk) disable iff (rst)
        o_restart |=> !o_done); // R8
    AST_RESET_CLEARS: assert property (@(posedge clk)
        rst |=> (acnt == '0 && ocnt == '0)); // R1

endmodule

// File: rtl/dwrom_lane_sel.sv
module dwrom_lane_sel
    import dwrom_pkg::*;
(
    input  logic            ce_n,
    input  logic            oe_n,
    input  logic            wide_sel,
    input  logic            id_flag,
    input  logic            ext_lsb,
    input  logic            addr0,
    input  logic            timing_ok,
    input  logic [DQ_W-1:0] word,
    output lane_s           lane,
    output logic            valid
);
    lane_e           mode;
    logic [DQ_W-1:0] chosen;

    always_comb begin
        if (ce_n || oe_n) mode = LANE_OFF;
        else if (wide_sel) mode = LANE_WORD;
        else               mode = LANE_BYTE;
    end

    always_comb begin
        if (id_flag)       chosen = ident(addr0);
        else if (wide_sel) chosen = word;
        else               chosen = half_of(word, ext_lsb);
    end

    always_comb begin
        unique case (mode)
            LANE_WORD: lane.drive = {DQ_W{1'b1}};
            LANE_BYTE: lane.drive = {{(DQ_W-BYTE_W){1'b0}}, {BYTE_W{1'b1}}};
            default:   lane.drive = '0;
        endcase
        valid     = (mode != LANE_OFF) && timing_ok;
        lane.data = valid ? (chosen & lane.drive) : '0;
    end

endmodule

// File: rtl/dwrom_port.sv
module dwrom_port
    import dwrom_pkg::*;
#(
    parameter int ADDR_W   = 8,
    parameter int ADDR_LAT = 4,
    parameter int OE_LAT   = 2
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              ld_en,
    input  logic [ADDR_W-1:0] ld_addr,
    input  logic [15:0]       ld_data,
    input  logic              ce_n,
    input  logic              oe_n,
    input  logic              wide_sel,
    input  logic              id_flag,
    input  logic [ADDR_W-1:0] addr,
    input  logic              ext_lsb,
    output logic [15:0]       dq_out,
    output logic [15:0]       dq_oe,
    output logic              data_valid,
    output logic              standby
);
    logic [DQ_W-1:0] word;
    logic            timing_ok;
    lane_s           lane;

    dwrom_store #(.ADDR_W(ADDR_W), .DATA_W(DQ_W)) u_store (
        .clk(clk), .we(ld_en), .waddr(ld_addr), .wdata(ld_data),
        .raddr(addr), .rdata(word)
    );

    dwrom_access_timer #(.ADDR_W(ADDR_W), .ADDR_LAT(ADDR_LAT), .OE_LAT(OE_LAT)) u_timer (
        .clk(clk), .rst(rst), .ce_n(ce_n), .oe_n(oe_n), .wide_sel(wide_sel),
        .id_flag(id_flag), .addr(addr), .ext_lsb(ext_lsb), .timing_ok(timing_ok)
    );

    dwrom_lane_sel u_lane (
        .ce_n(ce_n), .oe_n(oe_n), .wide_sel(wide_sel), .id_flag(id_flag),
        .ext_lsb(ext_lsb), .addr0(addr[0]), .timing_ok(timing_ok),
        .word(word), .lane(lane), .valid(data_valid)
    );

    assign dq_out  = lane.data;
    assign dq_oe   = lane.drive;
    assign standby = ce_n;

    AST_STANDBY_HIZ: assert property (@(posedge clk) disable iff (rst)
        ce_n |-> (dq_oe == '0 && standby)); // R5
    AST_BYTE_UPPER_HIZ: assert property (@(posedge clk) disable iff (rst)
        !wide_sel |-> (dq_oe[15:8] == '0)); // R3
    AST_VALID_GATED: assert property (@(posedge clk) disable iff (rst)
        data_valid |-> (!ce_n && !oe_n)); // R4
    AST_ID_UPPER_ZERO: assert property (@(posedge clk) disable iff (rst)
        (id_flag && data_valid) |-> (dq_out[15:8] == '0)); // R6
    AST_QUIET_INVALID: assert property (@(posedge clk) disable iff (rst)
        !data_valid |-> (dq_out == '0)); // R10

endmodule

// File: tb/tb_dwrom_port.sv
module tb_dwrom_port;
    localparam int AW = 8;
    localparam int AL = 4;
    localparam int OL = 2;

    logic          clk = 1'b0;
    logic          rst, ld_en, ce_n, oe_n, wide_sel, id_flag, ext_lsb;
    logic [AW-1:0] ld_addr, addr;
    logic [15:0]   ld_data, dq_out, dq_oe;
    logic          data_valid, standby;

    dwrom_port #(.ADDR_W(AW), .ADDR_LAT(AL), .OE_LAT(OL)) dut (
        .clk(clk), .rst(rst), .ld_en(ld_en), .ld_addr(ld_addr), .ld_data(ld_data),
        .ce_n(ce_n), .oe_n(oe_n), .wide_sel(wide_sel), .id_flag(id_flag),
        .addr(addr), .ext_lsb(ext_lsb), .dq_out(dq_out), .dq_oe(dq_oe),
        .data_valid(data_valid), .standby(standby)
    );

    always #5 clk = ~clk;

    int          n_chk = 0;
    int          n_bad = 0;
    bit          done  = 0;
    string       req   = "R1";
    logic [15:0] ref_mem [1 << AW];
    int          a_age, o_age;
    logic [AW-1:0] p_addr;
    logic        p_w, p_id, p_lsb;

    always @(posedge clk) begin
        if (rst) begin
            a_age = 0; o_age = 0; p_addr = '0; p_w = 0; p_id = 0; p_lsb = 0;
        end else begin
            if (ce_n || addr != p_addr || wide_sel != p_w || id_flag != p_id
                || (!wide_sel && ext_lsb != p_lsb)) a_age = 0;
            else if (a_age < AL) a_age = a_age + 1;
            if (ce_n || oe_n) o_age = 0;
            else if (o_age < OL) o_age = o_age + 1;
            p_addr = addr; p_w = wide_sel; p_id = id_flag; p_lsb = ext_lsb;
        end
    end

    task automatic cmp(string what, logic [15:0] act, logic [15:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s %s: actual=%h expected=%h", req, what, act, exp);
        end
    endtask

    task automatic step();
        logic        en, v;
        logic [15:0] mask, val, w;
        @(negedge clk);
        en   = !ce_n && !oe_n;
        mask = !en ? 16'h0000 : (wide_sel ? 16'hFFFF : 16'h00FF);
        w    = ref_mem[addr];
        if (id_flag)       val = addr[0] ? 16'h00B8 : 16'h0020;
        else if (wide_sel) val = w;
        else               val = ext_lsb ? {8'h00, w[15:8]} : {8'h00, w[7:0]};
        v    = en && !rst && a_age >= AL && o_age >= OL;
        cmp("dq_oe", dq_oe, mask);
        cmp("dq_out", dq_out, v ? (val & mask) : 16'h0000);
        cmp("data_valid", {15'd0, data_valid}, {15'd0, v});
        cmp("standby", {15'd0, standby}, {15'd0, ce_n});
    endtask

    task automatic run(int n);
        for (int i = 0; i < n; i++) step();
    endtask

    task automatic finish_up();
        if (!done) begin
            done = 1;
            $display("test done: total=%0d bad=%0d", n_chk, n_bad);
            $finish;
        end
    endtask

    initial begin
        #200000;
        n_chk++; n_bad++;
        $display("FAIL watchdog: actual=hung expected=finished");
        finish_up();
    end

    initial begin
        rst = 1; ld_en = 0; ld_addr = '0; ld_data = '0; ce_n = 1; oe_n = 1;
        wide_sel = 1; id_flag = 0; addr = '0; ext_lsb = 0;
        req = "R1"; run(3);
        for (int i = 0; i < (1 << AW); i++) begin
            ld_en = 1; ld_addr = AW'(i);
            ld_data = 16'(i * 16'h9E37) ^ 16'h5A3C;
            ref_mem[i] = ld_data;
            @(negedge clk);
        end
        ld_en = 0;
        rst = 0;
        req = "R1"; run(2);
        // R2 / R7: word read, then a new address restarts the wait
        req = "R2"; ce_n = 0; oe_n = 0; addr = 8'h05; run(7);
        req = "R7"; addr = 8'hFF; run(6);
        // R8: output gate falls after the address has settled
        req = "R8"; oe_n = 1; addr = 8'h3C; run(6);
        oe_n = 0; run(4);
        // R4: output disable
        req = "R4"; oe_n = 1; run(3);
        oe_n = 0; run(3);
        // R3: byte mode, shared pin picks the half
        req = "R3"; wide_sel = 0; ext_lsb = 0; addr = 8'h81; run(6);
        ext_lsb = 1; run(6);
        // R9: width switch while enabled
        req = "R9"; wide_sel = 1; run(6);
        wide_sel = 0; run(1);
        run(5);
        // R6: identification codes in both widths
        req = "R6"; wide_sel = 1; id_flag = 1; addr = 8'h00; run(6);
        addr = 8'h01; run(6);
        wide_sel = 0; ext_lsb = 1; run(6);
        id_flag = 0; wide_sel = 1; addr = 8'h10; run(6);
        // R5: standby with output gate low
        req = "R5"; ce_n = 1; oe_n = 0; run(4);
        ce_n = 0; run(6);
        // R10: short enable pulses never show data
        req = "R10"; ce_n = 1; run(1); ce_n = 0; run(2); addr = 8'h11; run(2);
        finish_up();
    end

endmodule